// File: doc/BRIEF.md
# Nested Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt lines and a single processor core. Each line has its own enable bit and an 8-bit priority, where a smaller number is more urgent. The block captures rising edges as pending requests. It picks the most urgent eligible request and compares it against the priority the core is currently running at. When the request wins, the block tells the core which handler to enter and where that handler's entry sits in the vector table. The table address is a fixed base plus four bytes per line number, so the core never has to poll a status register to find the source.

Nesting is tracked with an internal stack of active levels. A split input divides each priority into a group part and a subpriority part. Only the group part is compared with the running level, so only the group part can cause preemption. The subpriority bits still order requests that are waiting. When the core signals a handler return while another request is waiting, the block hands over the next handler in that same cycle and marks the entry as chained. It does not unwind to the interrupted level first. Saving core registers and fetching the vector word are left to the core.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `enter_o` and `enter_chain_o` are low, `depth_o` is 0 and `exec_prio_o` is 256, which means no handler is running.
- R2: A rising edge on an enabled line with no handler running produces a one-cycle `enter_o` pulse after the second clock edge from the edge. `enter_id_o` carries the line number and `enter_vec_o` carries `VEC_BASE + 4*line`.
- R3: When several eligible requests are pending, the one with the smallest priority value is entered first. Equal priority values go to the smaller line number.
- R4: A pending request on a line whose enable bit is 0 is never entered. It stays pending and is entered in the cycle after its enable bit is set.
- R5: A request preempts the running handler only when its group value is strictly below `exec_prio_o`. Preemption raises `depth_o` by one. A request with an equal or larger group value waits.
- R6: With `sub_bits_i = S`, the group value of a priority P is P with its S low bits cleared, and all bits are cleared for S >= 8. `exec_prio_o` shows the group value of the newest running handler.
- R7: A one-cycle `exit_i` with no eligible waiting request removes the newest level. `exec_prio_o` returns to the level below, or to 256 when the stack is empty.
- R8: When `exit_i` arrives and a waiting request's group value is below the level under the one being left, that request is entered in the same cycle. `enter_chain_o` goes high with `enter_o` and `depth_o` is unchanged.
- R9: A new edge on a line whose handler is running never preempts that handler. It is held pending and chained when the handler exits.
- R10: `depth_o` never exceeds `DEPTH`. While the stack is full, no request is entered except by chaining on an exit.
- R11: `exit_i` with an empty stack is ignored. Depth and running level stay at 0 and 256, and no chained entry occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | Interrupt lines; a rising edge sets pending |
| irq_en_i | input | N_IRQ | Per-line enable |
| irq_prio_i | input | 8*N_IRQ | Per-line priority, line k in bits [8k+7:8k] |
| sub_bits_i | input | 4 | Number of low priority bits that form the subpriority |
| exit_i | input | 1 | Handler return pulse from the core |
| enter_o | output | 1 | One-cycle handler entry pulse |
| enter_id_o | output | ID_W | Line number of the entered handler |
| enter_vec_o | output | ADDR_W | Vector table address of the entered handler |
| enter_chain_o | output | 1 | Entry was chained directly from a return |
| exec_prio_o | output | 9 | Current running group level, 256 when idle |
| depth_o | output | SP_W | Number of nested active handlers |

## Verification
The hardest situation to reach is a return that happens with the stack full and a more urgent request waiting. Entry must then happen by chaining while no ordinary push is allowed. The bench reaches it by giving each successive line a more urgent priority and pulsing the lines in order until the stack holds `DEPTH` levels. It then pulses one more line and issues a return. The grouping split is swept over every value from 0 to 8 with a fixed pair of priorities, so preemption and chaining each occur for some splits. Every pair of lines is also raised together with priorities that include ties.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
    localparam int PRIO_W    = 8;
    localparam int MAX_LINES = 240;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [PRIO_W:0]   level_t;
    typedef logic [3:0]        split_t;

    localparam level_t LEVEL_IDLE = level_t'(1 << PRIO_W);

    // Group value: priority with the subpriority bits cleared.
    function automatic level_t group_of(input prio_t p, input split_t s);
        prio_t keep;
        if (int'(s) >= PRIO_W) keep = '0;
        else                   keep = prio_t'({PRIO_W{1'b1}} << s);
        return {1'b0, p & keep};
    endfunction
endpackage

// File: rtl/prio_irq_pend.sv
module prio_irq_pend #(
    parameter int N_IRQ = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_IRQ-1:0] irq_i,
    input  logic [N_IRQ-1:0] clr_i,
    output logic [N_IRQ-1:0] pend_o
);
    typedef struct packed {
        logic [N_IRQ-1:0] line;
        logic [N_IRQ-1:0] pend;
    } pend_state_t;

    pend_state_t      st_d, st_q;
    logic [N_IRQ-1:0] pend_nx;

    // A fresh edge sets pending even in the cycle the old request is taken.
    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        assign pend_nx[g] = (irq_i[g] & ~st_q.line[g]) | (st_q.pend[g] & ~clr_i[g]);
    end

    always_comb begin
        st_d.line = irq_i;
        st_d.pend = pend_nx;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb import prio_irq_pkg::*; #(
    parameter int N_IRQ = 8,
    parameter int ID_W  = 3
) (
    input  logic [N_IRQ-1:0]        elig_i,
    input  logic [N_IRQ*PRIO_W-1:0] prio_i,
    output logic                    valid_o,
    output logic [ID_W-1:0]         id_o,
    output prio_t                   prio_o
);
    logic            found;
    logic [ID_W-1:0] win_id;
    prio_t           win_prio;

    // Strict compare keeps the lower line number on equal priority.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < N_IRQ; i++) begin
            if (elig_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

    assign valid_o = found;
    assign id_o    = win_id;
    assign prio_o  = win_prio;
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack import prio_irq_pkg::*; #(
    parameter int N_IRQ = 8,
    parameter int DEPTH = 4,
    parameter int ID_W  = 3,
    parameter int SP_W  = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [ID_W-1:0]  id_i,
    input  level_t           lvl_i,
    output logic [SP_W-1:0]  sp_o,
    output level_t           top_lvl_o,
    output level_t           under_lvl_o,
    output logic [N_IRQ-1:0] act_o,
    output logic [N_IRQ-1:0] act_under_o
);
    typedef struct packed {
        logic [DEPTH-1:0][ID_W-1:0] ids;
        logic [DEPTH-1:0][PRIO_W:0] lvls;
        logic [SP_W-1:0]            sp;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        int sp_n;
        sp_n = int'(st_q.sp);
        st_d = st_q;
        if (push_i && pop_i) begin
            if (sp_n > 0) begin
                st_d.ids[sp_n-1]  = id_i;
                st_d.lvls[sp_n-1] = lvl_i;
            end
        end else if (push_i) begin
            if (sp_n < DEPTH) begin
                st_d.ids[sp_n]  = id_i;
                st_d.lvls[sp_n] = lvl_i;
                st_d.sp         = st_q.sp + 1'b1;
            end
        end else if (pop_i) begin
            if (sp_n > 0) st_d.sp = st_q.sp - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        int sp_n;
        sp_n        = int'(st_q.sp);
        top_lvl_o   = LEVEL_IDLE;
        under_lvl_o = LEVEL_IDLE;
        act_o       = '0;
        act_under_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < sp_n) begin
                if (k == sp_n - 1) top_lvl_o   = st_q.lvls[k];
                if (k == sp_n - 2) under_lvl_o = st_q.lvls[k];
                if (int'(st_q.ids[k]) < N_IRQ) begin
                    act_o[st_q.ids[k]] = 1'b1;
                    if (k < sp_n - 1) act_under_o[st_q.ids[k]] = 1'b1;
                end
            end
        end
    end

    assign sp_o = st_q.sp;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import prio_irq_pkg::*; #(
    parameter int              N_IRQ    = 8,
    parameter int              DEPTH    = 4,
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_1000,
    localparam int             ID_W     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int             SP_W     = $clog2(DEPTH + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [N_IRQ-1:0]        irq_i,
    input  logic [N_IRQ-1:0]        irq_en_i,
    input  logic [N_IRQ*PRIO_W-1:0] irq_prio_i,
    input  logic [3:0]              sub_bits_i,
    input  logic                    exit_i,
    output logic                    enter_o,
    output logic [ID_W-1:0]         enter_id_o,
    output logic [ADDR_W-1:0]       enter_vec_o,
    output logic                    enter_chain_o,
    output logic [PRIO_W:0]         exec_prio_o,
    output logic [SP_W-1:0]         depth_o
);
    typedef struct packed {
        logic              enter;
        logic              chain;
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] vec;
    } out_t;

    out_t             st_d, st_q;
    logic [N_IRQ-1:0] pend, clr, elig, act, act_under;
    logic             best_v, do_exit, take, room;
    logic [ID_W-1:0]  best_id;
    prio_t            best_prio;
    level_t           top_lvl, under_lvl, ref_lvl, best_lvl;
    logic [SP_W-1:0]  sp;

    prio_irq_pend #(.N_IRQ(N_IRQ)) u_pend (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .irq_i  (irq_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    // Eligibility and reference level, as seen after any return this cycle.
    always_comb begin
        do_exit = exit_i && (sp != '0);
        ref_lvl = do_exit ? under_lvl : top_lvl;
        elig    = pend & irq_en_i & ~(do_exit ? act_under : act);
    end

    prio_irq_arb #(.N_IRQ(N_IRQ), .ID_W(ID_W)) u_arb (
        .elig_i  (elig),
        .prio_i  (irq_prio_i),
        .valid_o (best_v),
        .id_o    (best_id),
        .prio_o  (best_prio)
    );

    prio_irq_stack #(.N_IRQ(N_IRQ), .DEPTH(DEPTH), .ID_W(ID_W), .SP_W(SP_W)) u_stack (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .push_i      (take),
        .pop_i       (do_exit),
        .id_i        (best_id),
        .lvl_i       (best_lvl),
        .sp_o        (sp),
        .top_lvl_o   (top_lvl),
        .under_lvl_o (under_lvl),
        .act_o       (act),
        .act_under_o (act_under)
    );

    always_comb begin
        best_lvl  = group_of(best_prio, sub_bits_i);
        room      = do_exit || (int'(sp) < DEPTH);
        take      = best_v && room && (best_lvl < ref_lvl);
        clr       = take ? (N_IRQ'(1) << best_id) : '0;
        st_d.enter = take;
        st_d.chain = take && do_exit;
        st_d.id    = take ? best_id : st_q.id;
        st_d.vec   = take ? VEC_BASE + (ADDR_W'(best_id) << 2) : st_q.vec;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign enter_o       = st_q.enter;
    assign enter_chain_o = st_q.chain;
    assign enter_id_o    = st_q.id;
    assign enter_vec_o   = st_q.vec;
    assign exec_prio_o   = top_lvl;
    assign depth_o       = sp;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
    parameter int                N_IRQ    = 8,
    parameter int                DEPTH    = 4,
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = 32'h0000_1000,
    parameter int                ID_W     = 3,
    parameter int                SP_W     = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [N_IRQ-1:0]  irq_en_i,
    input logic              exit_i,
    input logic              enter_o,
    input logic [ID_W-1:0]   enter_id_o,
    input logic [ADDR_W-1:0] enter_vec_o,
    input logic              enter_chain_o,
    input logic [8:0]        exec_prio_o,
    input logic [SP_W-1:0]   depth_o
);
    logic [N_IRQ-1:0] en_prev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_prev <= '0;
        else         en_prev <= irq_en_i;
    end

    // R2
    vec_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_o |-> enter_vec_o == VEC_BASE + (ADDR_W'(enter_id_o) << 2));

    // R4
    enabled_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_o |-> en_prev[enter_id_o]);

    // R5
    nest_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enter_o && !enter_chain_o) |-> depth_o == $past(depth_o) + 1'b1);

    // R5
    strict_preempt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enter_o && !enter_chain_o) |-> exec_prio_o < $past(exec_prio_o));

    // R8
    chain_with_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_chain_o |-> enter_o);

    // R8
    chain_keeps_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        enter_chain_o |-> depth_o == $past(depth_o));

    // R10
    depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(depth_o) <= DEPTH);

    // R11
    empty_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exit_i && depth_o == '0) |=> !enter_chain_o);
endmodule

bind prio_irq_ctrl prio_irq_chk #(
    .N_IRQ(N_IRQ), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE),
    .ID_W(ID_W), .SP_W(SP_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .irq_en_i      (irq_en_i),
    .exit_i        (exit_i),
    .enter_o       (enter_o),
    .enter_id_o    (enter_id_o),
    .enter_vec_o   (enter_vec_o),
    .enter_chain_o (enter_chain_o),
    .exec_prio_o   (exec_prio_o),
    .depth_o       (depth_o)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module prio_irq_ctrl_tb;
    localparam int          N    = 8;
    localparam int          D    = 4;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0;
    logic [N-1:0]  en  = '1;
    logic [N*8-1:0] prio = '1;
    logic [3:0]    split = '0;
    logic          ex = 1'b0;
    logic          enter, chain;
    logic [2:0]    id;
    logic [31:0]   vec;
    logic [8:0]    execp;
    logic [2:0]    depth;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl #(.N_IRQ(N), .DEPTH(D), .ADDR_W(32), .VEC_BASE(BASE)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .irq_en_i(en), .irq_prio_i(prio),
        .sub_bits_i(split), .exit_i(ex), .enter_o(enter), .enter_id_o(id),
        .enter_vec_o(vec), .enter_chain_o(chain), .exec_prio_o(execp), .depth_o(depth)
    );

    function automatic logic [8:0] grp(input logic [7:0] p, input int s);
        if (s >= 8) return 9'd0;
        return {1'b0, p & (8'hFF << s)};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input logic [N-1:0] m);
        irq = m;
        step(1);
        irq = '0;
        step(1);
    endtask

    task automatic leave();
        ex = 1'b1;
        step(1);
        ex = 1'b0;
    endtask

    task automatic set_prio(input int i, input logic [7:0] p);
        prio[i*8 +: 8] = p;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1 reset state
        check("R1 enter", enter, 0);
        check("R1 depth", depth, 0);
        check("R1 exec", execp, 9'h100);
        rst_n = 1'b1;
        step(2);
        check("R1 idle after release", enter, 0);

        // R2 and R7: every line alone
        for (int i = 0; i < N; i++) begin
            set_prio(i, 8'(i * 16 + 3));
            fire(N'(1) << i);
            check("R2 enter", enter, 1);
            check("R2 id", id, i);
            check("R2 vec", vec, BASE + 4 * i);
            check("R6 exec", execp, grp(8'(i * 16 + 3), 0));
            step(1);
            check("R2 single pulse", enter, 0);
            leave();
            check("R7 depth", depth, 0);
            check("R7 exec idle", execp, 9'h100);
        end

        // R3, R5, R8: every pair raised together
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < N; i++) begin
                for (int j = i + 1; j < N; j++) begin
                    logic [7:0] pa, pb;
                    int w, l;
                    pa = 8'(((i * 5 + k * 3) % 4) * 16);
                    pb = 8'(((j * 3 + k) % 4) * 16);
                    set_prio(i, pa);
                    set_prio(j, pb);
                    w = (pb < pa) ? j : i;
                    l = (w == i) ? j : i;
                    fire((N'(1) << i) | (N'(1) << j));
                    check("R3 winner", id, w);
                    check("R3 enter", enter, 1);
                    step(1);
                    check("R5 no preempt on equal or worse", enter, 0);
                    leave();
                    check("R8 chain", chain, 1);
                    check("R8 chained id", id, l);
                    check("R8 depth kept", depth, 1);
                    leave();
                    check("R7 drained", depth, 0);
                end
            end
        end

        // R4 disabled line
        set_prio(2, 8'h40);
        en[2] = 1'b0;
        fire(N'(1) << 2);
        step(3);
        check("R4 not entered", depth, 0);
        check("R4 no pulse", enter, 0);
        en[2] = 1'b1;
        step(1);
        check("R4 entered when enabled", enter, 1);
        check("R4 id", id, 2);
        leave();

        // R5, R6, R7, R8: grouping split sweep
        set_prio(0, 8'h50);
        set_prio(1, 8'h48);
        for (int s = 0; s <= 8; s++) begin
            logic pre;
            split = 4'(s);
            pre = grp(8'h48, s) < grp(8'h50, s);
            fire(N'(1));
            check("R6 base entry", id, 0);
            check("R6 base level", execp, grp(8'h50, s));
            fire(N'(2));
            check("R5 preempt by group", enter, pre);
            check("R6 exec after", execp, pre ? grp(8'h48, s) : grp(8'h50, s));
            if (pre) begin
                check("R5 depth", depth, 2);
                leave();
                check("R7 no chain", chain, 0);
                check("R7 back to base", execp, grp(8'h50, s));
                leave();
            end else begin
                leave();
                check("R8 chain on split", chain, 1);
                check("R8 chain id", id, 1);
                leave();
            end
            check("R7 empty", depth, 0);
        end
        split = 4'd0;

        // R9 self re-assertion
        set_prio(3, 8'h20);
        fire(N'(1) << 3);
        check("R9 first entry", id, 3);
        fire(N'(1) << 3);
        check("R9 no self preempt", enter, 0);
        check("R9 depth", depth, 1);
        leave();
        check("R9 chained", chain, 1);
        check("R9 chained id", id, 3);
        leave();
        check("R9 drained", depth, 0);

        // R10 full stack then chain
        for (int i = 0; i < N; i++) set_prio(i, 8'((7 - i) * 16));
        for (int i = 0; i < D; i++) begin
            fire(N'(1) << i);
            check("R10 nested entry", enter, 1);
        end
        check("R10 full depth", depth, D);
        fire(N'(1) << 4);
        check("R10 blocked when full", enter, 0);
        check("R10 depth held", depth, D);
        leave();
        check("R10 chain on exit", chain, 1);
        check("R10 chain id", id, 4);
        check("R10 exec", execp, 9'h030);
        for (int i = 0; i < D; i++) leave();
        check("R10 drained", depth, 0);

        // R11 exit with empty stack
        leave();
        check("R11 depth", depth, 0);
        check("R11 exec", execp, 9'h100);
        check("R11 no chain", chain, 0);
        step(2);
        check("R11 no entry", enter, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule